// File: doc/BRIEF.md
# I/O Interrupt Redirection Controller

This block gathers interrupt requests from a bank of external input lines and turns them into interrupt messages on a single outbound message port. Each line has its own redirection entry. The entry holds the vector to send, the delivery mode, the destination addressing mode, the destination ID, the trigger mode and a mask bit. Each entry also has a read-only remote-IRR status bit. Edge-triggered lines send one message per rising edge. Level-triggered lines send one message and then wait for an end-of-interrupt (EOI) whose vector matches before they can fire again.

Software reaches the block through two registers: an index register and a data register. The data register reads and writes whichever internal word the index selects. The internal words are:
- the identification word (ID field writable),
- a read-only version word,
- an arbitration word that copies the ID,
- two words per line for the redirection entries.

Messages leave over a valid/ready handshake. When several lines want service at once, the lowest-numbered line goes first. A message is held stable until it is accepted. Each message carries the trigger mode, the destination mode and the destination field, so the receiver can tell level from edge and can decode a physical ID or a logical bitmask.

Top module: `irq_router`

## Requirements
- R1: After reset, `msg_valid_o` is 0, the ID field reads 0, and every entry's low word reads 0x00010000: mask bit 16 set, remote-IRR bit 14 clear, trigger bit 15 clear (edge).
- R2: In the identification word (index 0x00), writes change only bits 27:24; every other bit reads 0. The arbitration word (index 0x02) reads the last ID written, in bits 27:24, and ignores writes to itself.
- R3: The version word (index 0x01) reads {8'h00, NUM_LINES-1, 8'h00, 8'h20}, which is 0x00170020 for 24 lines, and it is unchanged by any write.
- R4: Line n's low word is at index 0x10+2n and its high word at 0x10+2n+1. The low word holds the vector in bits 7:0, the delivery mode in 10:8, the destination mode in 11 (1 = logical), remote-IRR in 14, the trigger in 15 (1 = level) and the mask in 16. The high word holds the destination in bits 31:24. Writing the high word leaves the low word unchanged. Unimplemented indices read 0.
- R5: An edge-mode line that is unmasked sends exactly one message per rising edge of its input.
- R6: A rising edge on an edge-mode line that is masked is discarded, and clearing the mask afterwards does not send it.
- R7: Sending a level-mode message sets that line's remote-IRR bit. While the bit is set, the line sends nothing more, so further pulses merge into the message already sent.
- R8: An EOI whose vector equals a level entry's vector clears that entry's remote-IRR. If the line is still high and unmasked, a new message follows. An EOI with any other vector changes nothing.
- R9: A level-mode line that is high while masked sends a message once its mask is cleared.
- R10: Every message carries the entry's vector, delivery mode, destination mode, destination field and trigger mode (`msg_level_o` = 1 for level).
- R11: When several lines are pending, they are sent lowest index first. While `msg_valid_o` is high and `msg_ready_i` is low, the message fields stay unchanged.
- R12: Remote-IRR is read-only: writing bit 14 of a low word has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = index register, 1 = data register |
| reg_wdata_i | input | 32 | Write data (bits 7:0 used for the index) |
| reg_rdata_o | output | 32 | Word selected by the current index |
| irq_lines_i | input | NUM_LINES | External interrupt inputs |
| eoi_valid_i | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector_i | input | 8 | Vector of the EOI broadcast |
| msg_valid_o | output | 1 | Message available |
| msg_ready_i | input | 1 | Receiver accepts the message |
| msg_vector_o | output | 8 | Message vector |
| msg_dlv_mode_o | output | 3 | Message delivery mode |
| msg_dest_mode_o | output | 1 | 0 = physical, 1 = logical |
| msg_dest_o | output | 8 | Destination ID or logical bitmask |
| msg_level_o | output | 1 | 1 = level-triggered source |
| msg_line_o | output | LINE_W | Index of the source line |

## Verification
The assertions assume that the receiver never sends an EOI for a level vector while that vector's own message is still waiting in the output stage. Because of this, remote-IRR is always set while a level message is pending. The stimulus issues EOIs only after the monitor has seen the message accepted. It holds interrupt pulses for at least two clock cycles, so the input synchronizer keeps every edge. Register accesses are driven one strobe per cycle on the falling clock edge.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned VEC_W      = 8;
   localparam int unsigned DLV_W      = 3;
   localparam int unsigned DEST_W     = 8;
   localparam int unsigned IDX_W      = 8;
   localparam int unsigned ID_W       = 4;

   localparam logic [IDX_W-1:0] IDX_IDENT = 8'h00;
   localparam logic [IDX_W-1:0] IDX_VERS  = 8'h01;
   localparam logic [IDX_W-1:0] IDX_ARBIT = 8'h02;
   localparam int unsigned      IDX_TABLE = 16;
   localparam logic [7:0]       VERSION   = 8'h20;

   // bit positions inside the low entry word
   localparam int unsigned B_DLV_LO   = 8;
   localparam int unsigned B_DMODE    = 11;
   localparam int unsigned B_RIRR     = 14;
   localparam int unsigned B_TRIG     = 15;
   localparam int unsigned B_MASK     = 16;
   // ID field position in identification / arbitration words and entry high word
   localparam int unsigned B_ID_LO    = 24;
   localparam int unsigned B_DEST_LO  = 24;

   typedef struct packed {
      logic [VEC_W-1:0]  vector;
      logic [DLV_W-1:0]  dlv_mode;
      logic              dest_mode;
      logic [DEST_W-1:0] dest;
      logic              level;
   } msg_t;
endpackage

// File: rtl/irqr_sync.sv
module irqr_sync #(
   parameter int unsigned WIDTH  = 24,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES == 0) begin : g_bypass
      assign sync_o = async_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
         end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign sync_o = stage_q[STAGES-1];
   end
endmodule

// File: rtl/irqr_line.sv
module irqr_line
   import irqr_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pin_i,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic              eoi_i,
   input  logic [VEC_W-1:0]  eoi_vec_i,
   input  logic              take_i,
   output logic [WORD_W-1:0] lo_o,
   output logic [WORD_W-1:0] hi_o,
   output logic              req_o,
   output msg_t              msg_o,
   output logic              rirr_o
);
   logic [VEC_W-1:0]  vec_q;
   logic [DLV_W-1:0]  dlv_q;
   logic              dmode_q;
   logic [DEST_W-1:0] dest_q;
   logic              level_q;
   logic              mask_q;
   logic              rirr_q;
   logic              pin_q;
   logic              pend_q;
   logic              rise;
   logic              eoi_hit;

   assign rise    = pin_i & ~pin_q;
   assign eoi_hit = eoi_i && (eoi_vec_i == vec_q) && level_q;

   // entry configuration
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vec_q   <= '0;
         dlv_q   <= '0;
         dmode_q <= 1'b0;
         level_q <= 1'b0;
         mask_q  <= 1'b1;
         dest_q  <= '0;
      end else begin
         if (wr_lo_i) begin
            vec_q   <= wdata_i[VEC_W-1:0];
            dlv_q   <= wdata_i[B_DLV_LO +: DLV_W];
            dmode_q <= wdata_i[B_DMODE];
            level_q <= wdata_i[B_TRIG];
            mask_q  <= wdata_i[B_MASK];
         end
         if (wr_hi_i) dest_q <= wdata_i[B_DEST_LO +: DEST_W];
      end
   end

   // edge capture, pending flag and remote-IRR
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pin_q  <= 1'b0;
         pend_q <= 1'b0;
         rirr_q <= 1'b0;
      end else begin
         pin_q <= pin_i;
         if (mask_q || level_q) pend_q <= 1'b0;
         else                   pend_q <= (pend_q & ~take_i) | rise;
         if (take_i && level_q) rirr_q <= 1'b1;
         else if (eoi_hit)      rirr_q <= 1'b0;
      end
   end

   assign req_o = level_q ? (pin_i & ~mask_q & ~rirr_q) : (pend_q & ~mask_q);

   always_comb begin
      lo_o                          = '0;
      lo_o[VEC_W-1:0]               = vec_q;
      lo_o[B_DLV_LO +: DLV_W]       = dlv_q;
      lo_o[B_DMODE]                 = dmode_q;
      lo_o[B_RIRR]                  = rirr_q;
      lo_o[B_TRIG]                  = level_q;
      lo_o[B_MASK]                  = mask_q;
      hi_o                          = '0;
      hi_o[B_DEST_LO +: DEST_W]     = dest_q;
   end

   assign msg_o  = '{vector: vec_q, dlv_mode: dlv_q, dest_mode: dmode_q,
                     dest: dest_q, level: level_q};
   assign rirr_o = rirr_q;
endmodule

// File: rtl/irqr_pick.sv
module irqr_pick #(
   parameter int unsigned N      = 24,
   parameter int unsigned LINE_W = 5
) (
   input  logic [N-1:0]      req_i,
   output logic              any_o,
   output logic [N-1:0]      gnt_o,
   output logic [LINE_W-1:0] idx_o
);
   // isolate lowest set bit
   assign gnt_o = req_i & (~req_i + N'(1));
   assign any_o = |req_i;

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (gnt_o[i]) idx_o = LINE_W'(i);
      end
   end
endmodule

// File: rtl/irq_router.sv
module irq_router
   import irqr_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 24,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned LINE_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 reg_we_i,
   input  logic                 reg_sel_i,
   input  logic [31:0]          reg_wdata_i,
   output logic [31:0]          reg_rdata_o,
   input  logic [NUM_LINES-1:0] irq_lines_i,
   input  logic                 eoi_valid_i,
   input  logic [7:0]           eoi_vector_i,
   output logic                 msg_valid_o,
   input  logic                 msg_ready_i,
   output logic [7:0]           msg_vector_o,
   output logic [2:0]           msg_dlv_mode_o,
   output logic                 msg_dest_mode_o,
   output logic [7:0]           msg_dest_o,
   output logic                 msg_level_o,
   output logic [LINE_W-1:0]    msg_line_o
);
   localparam int unsigned TABLE_END = IDX_TABLE + 2 * NUM_LINES;

   if (NUM_LINES < 1 || NUM_LINES > 120) begin : g_bad_lines
      $error("NUM_LINES must lie in 1..120 to fit the 8-bit index space");
   end
   if (SYNC_STAGES > 3) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..3");
   end

   logic [IDX_W-1:0]     idx_q;
   logic [ID_W-1:0]      id_q;
   logic [ID_W-1:0]      arb_q;
   logic [NUM_LINES-1:0] pins_s;
   logic [NUM_LINES-1:0] req_vec;
   logic [NUM_LINES-1:0] gnt_vec;
   logic [NUM_LINES-1:0] take_vec;
   logic [NUM_LINES-1:0] rirr_vec;
   logic [WORD_W-1:0]    lo_a [NUM_LINES];
   logic [WORD_W-1:0]    hi_a [NUM_LINES];
   msg_t                 msg_a [NUM_LINES];
   logic                 any_req;
   logic [LINE_W-1:0]    pick_idx;
   logic                 load;
   logic                 data_we;
   msg_t                 msg_q;
   logic                 valid_q;
   logic [LINE_W-1:0]    line_q;

   assign data_we = reg_we_i & reg_sel_i;

   // index, identification and arbitration registers
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         idx_q <= '0;
         id_q  <= '0;
         arb_q <= '0;
      end else begin
         if (reg_we_i && !reg_sel_i) idx_q <= reg_wdata_i[IDX_W-1:0];
         if (data_we && idx_q == IDX_IDENT) begin
            id_q  <= reg_wdata_i[B_ID_LO +: ID_W];
            arb_q <= reg_wdata_i[B_ID_LO +: ID_W];
         end
      end
   end

   irqr_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (irq_lines_i),
      .sync_o  (pins_s)
   );

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      logic wr_lo, wr_hi;
      assign wr_lo = data_we && (idx_q == IDX_W'(IDX_TABLE + 2 * n));
      assign wr_hi = data_we && (idx_q == IDX_W'(IDX_TABLE + 2 * n + 1));
      irqr_line u_line (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .pin_i     (pins_s[n]),
         .wr_lo_i   (wr_lo),
         .wr_hi_i   (wr_hi),
         .wdata_i   (reg_wdata_i),
         .eoi_i     (eoi_valid_i),
         .eoi_vec_i (eoi_vector_i),
         .take_i    (take_vec[n]),
         .lo_o      (lo_a[n]),
         .hi_o      (hi_a[n]),
         .req_o     (req_vec[n]),
         .msg_o     (msg_a[n]),
         .rirr_o    (rirr_vec[n])
      );
   end

   irqr_pick #(.N(NUM_LINES), .LINE_W(LINE_W)) u_pick (
      .req_i (req_vec),
      .any_o (any_req),
      .gnt_o (gnt_vec),
      .idx_o (pick_idx)
   );

   assign load     = !valid_q || msg_ready_i;
   assign take_vec = load ? gnt_vec : '0;

   // outbound message stage
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= 1'b0;
         msg_q   <= '0;
         line_q  <= '0;
      end else if (load) begin
         valid_q <= any_req;
         if (any_req) begin
            msg_q  <= msg_a[pick_idx];
            line_q <= pick_idx;
         end
      end
   end

   assign msg_valid_o     = valid_q;
   assign msg_vector_o    = msg_q.vector;
   assign msg_dlv_mode_o  = msg_q.dlv_mode;
   assign msg_dest_mode_o = msg_q.dest_mode;
   assign msg_dest_o      = msg_q.dest;
   assign msg_level_o     = msg_q.level;
   assign msg_line_o      = line_q;

   // read path
   logic [IDX_W-1:0]  tbl_off;
   logic [LINE_W-1:0] tbl_line;
   assign tbl_off  = idx_q - IDX_W'(IDX_TABLE);
   assign tbl_line = tbl_off[LINE_W:1];

   always_comb begin
      reg_rdata_o = '0;
      if (idx_q == IDX_IDENT) begin
         reg_rdata_o[B_ID_LO +: ID_W] = id_q;
      end else if (idx_q == IDX_VERS) begin
         reg_rdata_o = {8'h00, 8'(NUM_LINES - 1), 8'h00, VERSION};
      end else if (idx_q == IDX_ARBIT) begin
         reg_rdata_o[B_ID_LO +: ID_W] = arb_q;
      end else if (int'(idx_q) >= int'(IDX_TABLE) && int'(idx_q) < int'(TABLE_END)) begin
         reg_rdata_o = tbl_off[0] ? hi_a[tbl_line] : lo_a[tbl_line];
      end
   end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
   parameter int unsigned NUM_LINES = 24,
   parameter int unsigned LINE_W    = 5
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 msg_valid_o,
   input logic                 msg_ready_i,
   input logic [7:0]           msg_vector_o,
   input logic [7:0]           msg_dest_o,
   input logic                 msg_level_o,
   input logic [LINE_W-1:0]    msg_line_o,
   input logic [NUM_LINES-1:0] rirr_i,
   input logic [7:0]           idx_i,
   input logic [31:0]          rdata_i
);
   localparam int unsigned TABLE_END = 16 + 2 * NUM_LINES;

   p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> !msg_valid_o);

   p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (msg_valid_o && !msg_ready_i) |=>
         (msg_valid_o && $stable(msg_vector_o) && $stable(msg_dest_o) &&
          $stable(msg_line_o) && $stable(msg_level_o)));

   p_rirr_while_pending_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (msg_valid_o && msg_level_o) |-> rirr_i[msg_line_o]);

   p_version_steady_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (idx_i == 8'h01 && $past(idx_i) == 8'h01) |-> $stable(rdata_i));

   p_unimpl_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(idx_i) > 2 && (int'(idx_i) < 16 || int'(idx_i) >= int'(TABLE_END)))
         |-> rdata_i == 32'h0);

   p_entry_zero_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(idx_i) >= 16 && int'(idx_i) < int'(TABLE_END) && !idx_i[0])
         |-> (rdata_i[31:17] == 15'h0 && rdata_i[13:12] == 2'b00));
endmodule

bind irq_router irq_router_chk #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .msg_valid_o  (msg_valid_o),
   .msg_ready_i  (msg_ready_i),
   .msg_vector_o (msg_vector_o),
   .msg_dest_o   (msg_dest_o),
   .msg_level_o  (msg_level_o),
   .msg_line_o   (msg_line_o),
   .rirr_i       (rirr_vec),
   .idx_i        (idx_q),
   .rdata_i      (reg_rdata_o)
);

// File: tb/test_irq_router.sv
module test_irq_router;
   localparam int unsigned N = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [N-1:0] lines = '0;
   logic        eoi_v = 1'b0;
   logic [7:0]  eoi_vec = '0;
   logic        m_valid;
   logic        m_ready = 1'b1;
   logic [7:0]  m_vec;
   logic [2:0]  m_dlv;
   logic        m_dmode;
   logic [7:0]  m_dest;
   logic        m_level;
   logic [4:0]  m_line;

   int n_chk = 0;
   int n_bad = 0;
   int n_msg = 0;
   logic [7:0] log_vec [64];
   logic [7:0] log_dest [64];
   logic [2:0] log_dlv [64];
   logic       log_dmode [64];
   logic       log_level [64];

   always #2.5 clk = ~clk;

   irq_router #(.NUM_LINES(N), .SYNC_STAGES(2)) i_irq_router (
      .clk_i           (clk),
      .rst_ni          (rst_n),
      .reg_we_i        (reg_we),
      .reg_sel_i       (reg_sel),
      .reg_wdata_i     (reg_wdata),
      .reg_rdata_o     (reg_rdata),
      .irq_lines_i     (lines),
      .eoi_valid_i     (eoi_v),
      .eoi_vector_i    (eoi_vec),
      .msg_valid_o     (m_valid),
      .msg_ready_i     (m_ready),
      .msg_vector_o    (m_vec),
      .msg_dlv_mode_o  (m_dlv),
      .msg_dest_mode_o (m_dmode),
      .msg_dest_o      (m_dest),
      .msg_level_o     (m_level),
      .msg_line_o      (m_line)
   );

   // message monitor
   always @(posedge clk) begin
      if (rst_n && m_valid && m_ready) begin
         if (n_msg < 64) begin
            log_vec[n_msg]   = m_vec;
            log_dest[n_msg]  = m_dest;
            log_dlv[n_msg]   = m_dlv;
            log_dmode[n_msg] = m_dmode;
            log_level[n_msg] = m_level;
         end
         n_msg = n_msg + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h expected %08h", tag, got, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] idx, input logic [31:0] data);
      @(negedge clk); reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = {24'h0, idx};
      @(negedge clk); reg_sel = 1'b1; reg_wdata = data;
      @(negedge clk); reg_we = 1'b0; reg_sel = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] idx, output logic [31:0] data);
      @(negedge clk); reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = {24'h0, idx};
      @(negedge clk); reg_we = 1'b0;
      data = reg_rdata;
   endtask

   task automatic send_eoi(input logic [7:0] v);
      @(negedge clk); eoi_v = 1'b1; eoi_vec = v;
      @(negedge clk); eoi_v = 1'b0;
   endtask

   task automatic idle(input int cycles);
      repeat (cycles) @(negedge clk);
   endtask

   task automatic pulse(input int line);
      @(negedge clk); lines[line] = 1'b1;
      idle(2);
      lines[line] = 1'b0;
      idle(2);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   // {write, index, data, expected read}; reads ignore data, writes ignore expected
   localparam logic [72:0] VEC [16] = '{
      {1'b0, 8'h00, 32'h0,        32'h00000000},   // R1 ID after reset
      {1'b1, 8'h00, 32'hFFFFFFFF, 32'h0},
      {1'b0, 8'h00, 32'h0,        32'h0F000000},   // R2 ID field only
      {1'b0, 8'h02, 32'h0,        32'h0F000000},   // R2 arbitration mirrors ID
      {1'b1, 8'h02, 32'h00000000, 32'h0},
      {1'b0, 8'h02, 32'h0,        32'h0F000000},   // R2 arbitration read-only
      {1'b0, 8'h01, 32'h0,        32'h00170020},   // R3 version
      {1'b1, 8'h01, 32'hFFFFFFFF, 32'h0},
      {1'b0, 8'h01, 32'h0,        32'h00170020},   // R3 version unchanged
      {1'b0, 8'h10, 32'h0,        32'h00010000},   // R1 line 0 masked
      {1'b0, 8'h3E, 32'h0,        32'h00010000},   // R1 line 23 masked
      {1'b0, 8'h03, 32'h0,        32'h00000000},   // R4 unimplemented
      {1'b0, 8'h40, 32'h0,        32'h00000000},   // R4 past table
      {1'b1, 8'h11, 32'hAB000000, 32'h0},
      {1'b0, 8'h11, 32'h0,        32'hAB000000},   // R4 high word
      {1'b0, 8'h10, 32'h0,        32'h00010000}    // R4 low word undisturbed
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      int base;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      chk("R1 msg_valid after reset", {31'h0, m_valid}, 32'h0);

      // table walk over the register space
      for (int i = 0; i < 16; i++) begin
         if (VEC[i][72]) begin
            wr_reg(VEC[i][71:64], VEC[i][63:32]);
         end else begin
            rd_reg(VEC[i][71:64], rd);
            chk($sformatf("R1/R2/R3/R4 table row %0d", i), rd, VEC[i][31:0]);
         end
      end

      // R12: remote-IRR bit cannot be written
      wr_reg(8'h10, 32'h00004055);
      rd_reg(8'h10, rd);
      chk("R12 remote-IRR read-only", rd, 32'h00000055);
      wr_reg(8'h10, 32'h00010000);

      // R5 / R10: edge line 3, logical mode, dest 0x0D, delivery mode 1
      wr_reg(8'h17, 32'h0D000000);
      wr_reg(8'h16, 32'h00000941);
      base = n_msg;
      pulse(3);
      idle(12);
      chk("R5 one message per edge", 32'(n_msg - base), 32'd1);
      chk("R10 vector", {24'h0, log_vec[base]}, 32'h41);
      chk("R10 dest bitmask", {24'h0, log_dest[base]}, 32'h0D);
      chk("R10 dest mode logical", {31'h0, log_dmode[base]}, 32'h1);
      chk("R10 delivery mode", {29'h0, log_dlv[base]}, 32'h1);
      chk("R10 edge trigger flag", {31'h0, log_level[base]}, 32'h0);
      pulse(3);
      idle(12);
      chk("R5 second edge second message", 32'(n_msg - base), 32'd2);

      // R6: masked edge is lost
      wr_reg(8'h16, 32'h00010941);
      base = n_msg;
      pulse(3);
      idle(8);
      wr_reg(8'h16, 32'h00000941);
      idle(12);
      chk("R6 masked edge dropped", 32'(n_msg - base), 32'd0);

      // R7 / R8: level line 5 vector 0x52
      wr_reg(8'h1B, 32'h01000000);
      wr_reg(8'h1A, 32'h00008052);
      base = n_msg;
      @(negedge clk); lines[5] = 1'b1;
      idle(12);
      chk("R7 level delivers once", 32'(n_msg - base), 32'd1);
      chk("R10 level trigger flag", {31'h0, log_level[base]}, 32'h1);
      rd_reg(8'h1A, rd);
      chk("R7 remote-IRR set", rd, 32'h0000C052);
      for (int k = 0; k < 3; k++) begin
         lines[5] = 1'b0; idle(3);
         lines[5] = 1'b1; idle(3);
      end
      idle(10);
      chk("R7 pulses merged", 32'(n_msg - base), 32'd1);
      send_eoi(8'h99);
      idle(12);
      chk("R8 other vector ignored", 32'(n_msg - base), 32'd1);
      rd_reg(8'h1A, rd);
      chk("R8 remote-IRR kept on other vector", rd, 32'h0000C052);
      send_eoi(8'h52);
      idle(12);
      chk("R8 still-high line re-fires", 32'(n_msg - base), 32'd2);
      @(negedge clk); lines[5] = 1'b0;
      idle(6);
      send_eoi(8'h52);
      idle(12);
      chk("R8 low line stays quiet", 32'(n_msg - base), 32'd2);
      rd_reg(8'h1A, rd);
      chk("R8 remote-IRR cleared", rd, 32'h00008052);

      // R9: masked level line delivers on unmask
      wr_reg(8'h1A, 32'h00018052);
      base = n_msg;
      @(negedge clk); lines[5] = 1'b1;
      idle(12);
      chk("R9 masked level held off", 32'(n_msg - base), 32'd0);
      wr_reg(8'h1A, 32'h00008052);
      idle(12);
      chk("R9 unmask delivers", 32'(n_msg - base), 32'd1);
      @(negedge clk); lines[5] = 1'b0;
      idle(4);
      send_eoi(8'h52);
      idle(6);

      // R11: lowest index first, held while not ready
      wr_reg(8'h14, 32'h00000022);
      wr_reg(8'h1E, 32'h00000077);
      @(negedge clk); m_ready = 1'b0;
      base = n_msg;
      lines[2] = 1'b1; lines[7] = 1'b1;
      idle(10);
      chk("R11 valid while stalled", {31'h0, m_valid}, 32'h1);
      chk("R11 lowest line offered", {24'h0, m_vec}, 32'h22);
      chk("R11 line index", {27'h0, m_line}, 32'd2);
      idle(5);
      chk("R11 held while stalled", {24'h0, m_vec}, 32'h22);
      m_ready = 1'b1;
      idle(10);
      chk("R11 both delivered", 32'(n_msg - base), 32'd2);
      chk("R11 first is line 2", {24'h0, log_vec[base]}, 32'h22);
      chk("R11 second is line 7", {24'h0, log_vec[base + 1]}, 32'h77);
      lines[2] = 1'b0; lines[7] = 1'b0;
      idle(5);

      summary();
      $finish;
   end
endmodule